// File: doc/BRIEF.md
# Chainable FIFO Slice with Ring Ownership Tokens

This block is one slice of a first-in first-out buffer. It works alone, or it joins a ring of identical slices that together act as one deeper FIFO. Alone, it holds up to `D` words and offers full, empty and over-half flags. It also offers a rewind command that sends reading back to the first stored word.

In a ring, each slice has two expansion outputs, one for writes and one for reads. Each output drives the matching expansion input of the next slice, and the last slice drives the first. Two ownership tokens travel around the ring. At any moment one slice owns writing and one slice owns reading. All slices share the write and read strobes, and a slice that does not own a token ignores that strobe. When the write owner fills its last physical location, it pulses its write expansion output low for one clock and hands the write token to its neighbour. The read token moves the same way when the owner reads its last location.

All flags are active low and read data is zero while no word is being delivered. The whole ring's flags and read data are therefore plain ORs of the slices' outputs, formed outside the slices. The mode is captured during the synchronous master reset.

Top module: `dxf_slice`

## Requirements
- R1: While `rst` is high at a clock edge, the slice goes to empty: `empty_n`=0, `full_n`=1, `half_n`=1, `rd_valid`=0, `rd_data`=0, and both expansion outputs are high.
- R2: Words leave in the order they were accepted, including across slice boundaries in a ring. A read accepted at an edge puts its word on `rd_data`, with `rd_valid`=1, right after that same edge.
- R3: `full_n` is 0 exactly when the slice holds `D` words. A write strobe while full is ignored and the stored contents do not change.
- R4: A read strobe while empty is ignored: after that edge `rd_valid`=0 and `rd_data`=0.
- R5: In standalone mode, `half_n` is 0 exactly when the slice holds more than `D/2` words.
- R6: In standalone mode, `rewind`=1 at an edge moves reading back to physical location 0. The word count becomes the number of writes since reset, capped at `D`. Read and write strobes in that same cycle are ignored.
- R7: The mode is sampled while `rst` is high. Standalone is selected when both expansion inputs are low and `first_n` is high. Any other combination selects ring mode.
- R8: In ring mode, the slice with `first_n`=0 at reset owns both tokens. A slice that does not own the write (read) token ignores write (read) strobes.
- R9: In ring mode, `xout_wr_n` is low during exactly the cycle in which the slice accepts a write to physical location `D-1`. The owner then gives up the token. A slice that samples `xin_wr_n` low at an edge owns writing from the next cycle.
- R10: In ring mode, `xout_rd_n` follows the same rule for reads of physical location `D-1`, and `xin_rd_n` passes read ownership the same way.
- R11: In ring mode, `half_n` stays 1 and `rewind` has no effect. A read strobed together with `rewind` still proceeds.
- R12: While `rd_valid` is 0, `rd_data` is all zeros. This lets a ring combine its slices' data with a plain OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset; also samples the mode |
| wr_en | input | 1 | Write strobe |
| wr_data | input | W | Word to write |
| rd_en | input | 1 | Read strobe |
| rd_data | output | W | Word read; zero when no read was accepted |
| rd_valid | output | 1 | High for one cycle after an accepted read |
| rewind | input | 1 | Standalone-only rewind of the read position |
| first_n | input | 1 | Low on the ring slice that starts with both tokens |
| xin_wr_n | input | 1 | Write-token pulse from the previous ring slice |
| xin_rd_n | input | 1 | Read-token pulse from the previous ring slice |
| xout_wr_n | output | 1 | Write-token pulse to the next ring slice |
| xout_rd_n | output | 1 | Read-token pulse to the next ring slice |
| full_n | output | 1 | Low when the slice is full |
| empty_n | output | 1 | Low when the slice is empty |
| half_n | output | 1 | Low when more than half full (standalone only) |

## Verification
The assertions assume that `D` is at least 2. They also assume that an expansion input is driven only by a ring neighbour's expansion output, or is tied low in standalone mode, so that a token pulse never lasts longer than one cycle. The bench keeps within this. It builds a three-slice ring wired output to input, with the write strobe, read strobe and rewind shared by all slices, and a separate standalone slice with its expansion inputs tied low. Strobe patterns are fixed arithmetic sequences, and a queue model in the bench supplies every expected word and flag.

// File: rtl/dxf_pkg.sv
package dxf_pkg;
  typedef enum logic {
    MODE_SOLO = 1'b0,
    MODE_RING = 1'b1
  } dxf_mode_e;
endpackage

// File: rtl/dxf_ram.sv
// Simple dual-port storage with a registered read port that clears when idle.
module dxf_ram #(
  parameter int W  = 9,
  parameter int D  = 512,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [D];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || !re) rdata <= '0;
    else            rdata <= mem[raddr];
  end
endmodule

// File: rtl/dxf_token.sv
// One ownership token: captured from the ring, released after the last location.
module dxf_token (
  input  logic clk,
  input  logic rst,
  input  logic ring,
  input  logic ring_at_rst,
  input  logic seed,
  input  logic xin_n,
  input  logic fire,
  input  logic at_last,
  output logic own,
  output logic xout_n
);
  logic own_q;
  logic pass;

  assign pass = ring && own_q && fire && at_last && !rst;

  always_ff @(posedge clk) begin
    if (rst)                 own_q <= ring_at_rst && seed;
    else if (ring && !xin_n) own_q <= 1'b1;
    else if (pass)           own_q <= 1'b0;
  end

  assign own    = own_q;
  assign xout_n = !pass;
endmodule

// File: rtl/dxf_slice.sv
module dxf_slice
  import dxf_pkg::*;
#(
  parameter int W = 9,
  parameter int D = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  input  logic         rewind,
  input  logic         first_n,
  input  logic         xin_wr_n,
  input  logic         xin_rd_n,
  output logic         xout_wr_n,
  output logic         xout_rd_n,
  output logic         full_n,
  output logic         empty_n,
  output logic         half_n
);
  localparam int AW = (D > 1) ? $clog2(D) : 1;
  localparam int CW = $clog2(D + 1);
  localparam logic [AW-1:0] LAST  = AW'(D - 1);
  localparam logic [CW-1:0] CAPC  = CW'(D);
  localparam logic [CW-1:0] HALFC = CW'(D / 2);

  dxf_mode_e     mode_q, mode_at_rst;
  logic          ring, ring_at_rst;
  logic          wr_own, rd_own;
  logic          rewind_go, wr_fire, rd_fire;
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q, count_d, hist_q;
  logic          full_q, empty_q, half_q, valid_q;

  // Mode capture during master reset
  assign mode_at_rst = (!xin_wr_n && !xin_rd_n && first_n) ? MODE_SOLO : MODE_RING;
  assign ring_at_rst = (mode_at_rst == MODE_RING);
  assign ring        = (mode_q == MODE_RING);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_at_rst;
  end

  // Strobe qualification
  assign rewind_go = rewind && !ring && !rst;
  assign wr_fire   = wr_en && (!ring || wr_own) && !full_q  && !rewind_go && !rst;
  assign rd_fire   = rd_en && (!ring || rd_own) && !empty_q && !rewind_go && !rst;

  // Ownership tokens
  dxf_token wr_tok_i (
    .clk(clk), .rst(rst), .ring(ring), .ring_at_rst(ring_at_rst), .seed(!first_n),
    .xin_n(xin_wr_n), .fire(wr_fire), .at_last(wptr_q == LAST),
    .own(wr_own), .xout_n(xout_wr_n)
  );

  dxf_token rd_tok_i (
    .clk(clk), .rst(rst), .ring(ring), .ring_at_rst(ring_at_rst), .seed(!first_n),
    .xin_n(xin_rd_n), .fire(rd_fire), .at_last(rptr_q == LAST),
    .own(rd_own), .xout_n(xout_rd_n)
  );

  // Storage
  dxf_ram #(.W(W), .D(D), .AW(AW)) ram_i (
    .clk(clk), .rst(rst),
    .we(wr_fire), .waddr(wptr_q), .wdata(wr_data),
    .re(rd_fire), .raddr(rptr_q), .rdata(rd_data)
  );

  // Pointers and write history
  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      hist_q <= '0;
    end else begin
      if (wr_fire) begin
        wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
        if (hist_q != CAPC) hist_q <= hist_q + 1'b1;
      end
      if (rewind_go)    rptr_q <= '0;
      else if (rd_fire) rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    end
  end

  // Occupancy
  always_comb begin
    count_d = count_q;
    if (rewind_go) begin
      count_d = hist_q;
    end else begin
      case ({wr_fire, rd_fire})
        2'b10:   count_d = count_q + 1'b1;
        2'b01:   count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      half_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      count_q <= count_d;
      full_q  <= (count_d == CAPC);
      empty_q <= (count_d == '0);
      half_q  <= !ring && (count_d > HALFC);
      valid_q <= rd_fire;
    end
  end

  assign full_n   = !full_q;
  assign empty_n  = !empty_q;
  assign half_n   = !half_q;
  assign rd_valid = valid_q;
endmodule

// File: rtl/dxf_slice_chk.sv
module dxf_slice_chk #(
  parameter int W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic         rd_en,
  input logic         rewind,
  input logic         full_n,
  input logic         empty_n,
  input logic         half_n,
  input logic         rd_valid,
  input logic [W-1:0] rd_data,
  input logic         xout_wr_n,
  input logic         xout_rd_n,
  input logic         ring
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !rd_en && !rewind) |=> !full_n);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    !empty_n |=> !rd_valid);

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    !xout_wr_n |=> xout_wr_n);

  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    !xout_rd_n |=> xout_rd_n);

  assert_solo_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !ring |-> (xout_wr_n && xout_rd_n));

  assert_ring_half_R11: assert property (@(posedge clk) disable iff (rst)
    ring |-> half_n);
endmodule

bind dxf_slice dxf_slice_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rewind(rewind),
  .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
  .rd_valid(rd_valid), .rd_data(rd_data),
  .xout_wr_n(xout_wr_n), .xout_rd_n(xout_rd_n), .ring(ring)
);

// File: tb/dxf_slice_tb_top.sv
module dxf_slice_tb_top;
  localparam int W = 8, D = 4, N = 3, CAP = N * D;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Ring of three slices
  logic r_wr, r_rd, r_rw;
  logic [W-1:0] r_wd;
  logic [W-1:0] rdd [N];
  logic rv [N], fn [N], en [N], hn [N], xw [N], xr [N];

  dxf_slice #(.W(W), .D(D)) dut_i (
    .clk(clk), .rst(rst), .wr_en(r_wr), .wr_data(r_wd), .rd_en(r_rd),
    .rd_data(rdd[0]), .rd_valid(rv[0]), .rewind(r_rw), .first_n(1'b0),
    .xin_wr_n(xw[2]), .xin_rd_n(xr[2]), .xout_wr_n(xw[0]), .xout_rd_n(xr[0]),
    .full_n(fn[0]), .empty_n(en[0]), .half_n(hn[0]));

  dxf_slice #(.W(W), .D(D)) s1_i (
    .clk(clk), .rst(rst), .wr_en(r_wr), .wr_data(r_wd), .rd_en(r_rd),
    .rd_data(rdd[1]), .rd_valid(rv[1]), .rewind(r_rw), .first_n(1'b1),
    .xin_wr_n(xw[0]), .xin_rd_n(xr[0]), .xout_wr_n(xw[1]), .xout_rd_n(xr[1]),
    .full_n(fn[1]), .empty_n(en[1]), .half_n(hn[1]));

  dxf_slice #(.W(W), .D(D)) s2_i (
    .clk(clk), .rst(rst), .wr_en(r_wr), .wr_data(r_wd), .rd_en(r_rd),
    .rd_data(rdd[2]), .rd_valid(rv[2]), .rewind(r_rw), .first_n(1'b1),
    .xin_wr_n(xw[1]), .xin_rd_n(xr[1]), .xout_wr_n(xw[2]), .xout_rd_n(xr[2]),
    .full_n(fn[2]), .empty_n(en[2]), .half_n(hn[2]));

  logic c_full_n, c_empty_n, c_valid;
  logic [W-1:0] c_data;
  assign c_full_n  = fn[0] | fn[1] | fn[2];
  assign c_empty_n = en[0] | en[1] | en[2];
  assign c_valid   = rv[0] | rv[1] | rv[2];
  assign c_data    = rdd[0] | rdd[1] | rdd[2];

  // Standalone slice
  logic s_wr, s_rd, s_rw;
  logic [W-1:0] s_wd, s_rdd;
  logic s_rv, s_xw, s_xr, s_fn, s_en, s_hn;

  dxf_slice #(.W(W), .D(D)) sa_i (
    .clk(clk), .rst(rst), .wr_en(s_wr), .wr_data(s_wd), .rd_en(s_rd),
    .rd_data(s_rdd), .rd_valid(s_rv), .rewind(s_rw), .first_n(1'b1),
    .xin_wr_n(1'b0), .xin_rd_n(1'b0), .xout_wr_n(s_xw), .xout_rd_n(s_xr),
    .full_n(s_fn), .empty_n(s_en), .half_n(s_hn));

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] q [$];
    int v;
    rst = 1'b1;
    r_wr = 0; r_rd = 0; r_rw = 0; r_wd = '0;
    s_wr = 0; s_rd = 0; s_rw = 0; s_wd = '0;
    step(); step();

    // R1 reset state
    chk(s_en == 0 && s_fn == 1 && s_hn == 1 && s_rv == 0, "R1 solo flags", {s_en, s_fn, s_hn, s_rv}, 4'b0110);
    chk(s_rdd == 0, "R1 solo data", s_rdd, 0);
    for (int s = 0; s < N; s++) begin
      chk(en[s] == 0 && fn[s] == 1 && hn[s] == 1 && rv[s] == 0, "R1 ring flags", {en[s], fn[s], hn[s], rv[s]}, 4'b0110);
      chk(xw[s] == 1 && xr[s] == 1, "R1 ring xout", {xw[s], xr[s]}, 2'b11);
    end
    rst = 1'b0;

    // Standalone fill, including one write beyond capacity
    for (int i = 0; i <= D; i++) begin
      int cnt;
      s_wr = 1; s_wd = W'(8'h20 + i);
      step();
      cnt = (i + 1 < D) ? i + 1 : D;
      chk(s_fn == (cnt != D), "R3 full flag", s_fn, cnt != D);
      chk(s_hn == !(cnt > D / 2), "R5 half flag", s_hn, !(cnt > D / 2));
      chk(s_en == 1, "R7 solo accepts writes", s_en, 1);
    end
    s_wr = 0;

    // Standalone drain, including one read beyond empty
    for (int i = 0; i <= D; i++) begin
      s_rd = 1;
      step();
      if (i < D) begin
        chk(s_rv == 1 && s_rdd == W'(8'h20 + i), "R2 solo order", s_rdd, 8'h20 + i);
      end else begin
        chk(s_rv == 0 && s_rdd == 0, "R4 empty read ignored", s_rdd, 0);
      end
    end
    chk(s_en == 0, "R4 solo empty", s_en, 0);

    // Rewind with a simultaneous read
    s_rw = 1; s_rd = 1;
    step();
    chk(s_rv == 0, "R6 strobe ignored on rewind", s_rv, 0);
    chk(s_en == 1 && s_fn == 0, "R6 count restored", {s_en, s_fn}, 2'b10);
    s_rw = 0;
    for (int i = 0; i < D; i++) begin
      step();
      chk(s_rv == 1 && s_rdd == W'(8'h20 + i), "R6 replay order", s_rdd, 8'h20 + i);
    end
    s_rd = 0;
    step();
    chk(s_en == 0, "R6 replay drained", s_en, 0);

    // Ring fill with hand-off pulses
    for (int i = 0; i <= CAP; i++) begin
      int cnt;
      r_wr = 1; r_wd = W'(8'h40 + i);
      #1;
      for (int s = 0; s < N; s++) begin
        bit exp_low;
        exp_low = (i < CAP) && (i % D == D - 1) && (s == i / D);
        chk(xw[s] == !exp_low, "R9 write hand-off pulse", xw[s], !exp_low);
      end
      step();
      cnt = (i + 1 < CAP) ? i + 1 : CAP;
      chk(c_full_n == (cnt != CAP), "R3 ring full", c_full_n, cnt != CAP);
      for (int s = 0; s < N; s++)
        chk(en[s] == (cnt > s * D), "R8 write ownership", en[s], cnt > s * D);
      if (i == D - 1) chk(hn[0] == 1, "R11 half disabled", hn[0], 1);
    end
    r_wr = 0;

    // Rewind ignored in ring mode; the read proceeds
    r_rw = 1; r_rd = 1;
    step();
    chk(c_valid == 1 && c_data == W'(8'h40), "R11 rewind ignored", c_data, 8'h40);
    r_rw = 0;

    // Ring drain with read hand-offs
    for (int i = 1; i <= CAP; i++) begin
      #1;
      for (int s = 0; s < N; s++) begin
        bit exp_low;
        exp_low = (i < CAP) && (i % D == D - 1) && (s == i / D);
        chk(xr[s] == !exp_low, "R10 read hand-off pulse", xr[s], !exp_low);
      end
      step();
      if (i < CAP) chk(c_valid == 1 && c_data == W'(8'h40 + i), "R2 ring order", c_data, 8'h40 + i);
      else         chk(c_valid == 0 && c_data == 0, "R4 ring empty read", c_data, 0);
    end
    r_rd = 0;
    chk(c_empty_n == 0, "R4 ring empty", c_empty_n, 0);

    // Streaming sweep across ring boundaries
    v = 0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      bit wok, rok;
      if (cyc < 60)       begin r_wr = 1;               r_rd = (cyc % 3 == 0); end
      else if (cyc < 120) begin r_wr = (cyc % 2 == 0);  r_rd = 1; end
      else                begin r_wr = (cyc % 4 != 0);  r_rd = (cyc % 4 == 1) || (cyc % 4 == 2); end
      r_wd = W'(v);
      wok = r_wr && (q.size() < CAP);
      rok = r_rd && (q.size() > 0);
      step();
      if (rok) begin
        chk(c_valid == 1 && c_data == q[0], "R2 stream order", c_data, q[0]);
        void'(q.pop_front());
      end else begin
        chk(c_valid == 0 && c_data == 0, "R12 idle data zero", c_data, 0);
      end
      if (wok) begin
        q.push_back(W'(v));
        v++;
      end
      chk(c_full_n == (q.size() != CAP), "R3 stream full", c_full_n, q.size() != CAP);
      chk(c_empty_n == (q.size() != 0), "R4 stream empty", c_empty_n, q.size() != 0);
    end
    r_wr = 0; r_rd = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule